// File: doc/BRIEF.md
# Dual-Sampled Capture Register with Timing-Error Recovery

This block is the output register bank placed after a slow combinational datapath such as an array multiplier. It holds a 2M+1 bit word: the 2M-bit result plus one extra bit. Each bit is sampled twice. A main flip-flop samples it on the rising edge of the normal clock. A shadow element samples it on the rising edge of a delayed copy of that clock, which arrives later in the same cycle. If the datapath settles after the main edge but before the delayed edge, the two samples differ. That difference exposes a setup violation that would otherwise pass unseen.

Each bit compares its two samples with an XOR. The per-bit mismatches are OR-reduced into one flag. A two-state controller acts on that flag.

- **RUN** is the normal sampling state.
- **FIX** is the one-cycle recovery state.

The controller has three transitions:

- **RUN→FIX** is taken when any bit mismatches at a main edge. On that edge every main flip-flop loads its shadow value instead of the bus, so the output holds the late, correct word. The registered error flag rises for the hold logic, which can then re-issue the operation with a longer latency.
- **FIX→RUN** is always taken on the next edge. During FIX the comparison is ignored, because the main register holds a restored value and not a bus sample.
- **RUN→RUN** is taken when all bits agree.

Top module: `razor_capture_bank`

## Requirements
- R1: While reset is asserted (active low, asynchronous), the output word is all zeros and the error flag is 0.
- R2: In state RUN with no mismatch, the word present on the data bus at a main clock rising edge appears on the output word after that edge, and the error flag is 0.
- R3: A data bus value that changes after a main edge but before the following delayed-clock edge is a late arrival. If it changes the word, the error flag is 1 for exactly the one cycle after the next main edge.
- R4: In that error cycle, the output word equals the value sampled at the delayed-clock edge (the late value) in every bit.
- R5: The word is 2M+1 bits wide. A late change confined to any single bit, including the topmost extra bit (bit 2M), raises the error flag.
- R6: In the recovery cycle (FIX), any mismatch is ignored. The next main edge loads the bus value normally and the error flag returns to 0.
- R7: A late transition that leaves the sampled word unchanged (both samples equal) raises no error and leaves the captured word on the output.
- R8: A late arrival in the first RUN cycle after recovery is detected again, giving a second error cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main sampling clock, rising edge |
| clk_dly | input | 1 | Delayed copy of clk used for the shadow sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | 2M+1 | Datapath result word to be captured |
| q_out | output | 2M+1 | Captured (and, on error, corrected) word |
| err_out | output | 1 | Timing-error flag to the hold logic, high for one cycle |

## Verification
The hardest situation to reach is a late arrival: a bus value that is wrong at the main edge but correct at the delayed edge. It is harder still when it lands in the recovery cycle or right after it. The bench drives each cycle's word in two phases. It first puts a "stale" word on the bus before the main edge. It then replaces it with the "good" word one nanosecond after the edge, which is before the delayed edge three nanoseconds later. Directed cycles place a late arrival inside FIX, back-to-back after FIX, in the top bit alone, and with stale equal to good. A seeded random run mixes on-time and late cycles against a bench model of the two states.

// File: rtl/razor_pkg.sv
package razor_pkg;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_FIX = 1'b1
    } rz_state_e;

endpackage

// File: rtl/razor_bit_cell.sv
module razor_bit_cell (
    input  logic clk,
    input  logic clk_dly,
    input  logic rst_n,
    input  logic d,
    input  logic restore,
    output logic q,
    output logic shadow,
    output logic mism
);

    // main sample, with restore mux in front
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= restore ? shadow : d;
    end

    // late sample on the delayed clock
    always_ff @(posedge clk_dly or negedge rst_n) begin
        if (!rst_n) shadow <= 1'b0;
        else        shadow <= d;
    end

    assign mism = q ^ shadow;

    // R2: without restore the main flop follows the bus
    a_r2_load_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !restore |=> (q == $past(d)));

    // R4: with restore the main flop takes the late sample
    a_r4_take_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (q == $past(shadow)));

endmodule

// File: rtl/razor_ctrl.sv
module razor_ctrl
    import razor_pkg::*;
#(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mism_vec,
    output logic         restore,
    output logic         err_flag
);

    rz_state_e state, state_nxt;
    logic      any_mism;

    assign any_mism = |mism_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN: state_nxt = any_mism ? ST_FIX : ST_RUN;
            ST_FIX: state_nxt = ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    // outputs: restore decided in RUN only, flag registered
    always_comb begin
        restore = 1'b0;
        unique case (state)
            ST_RUN: restore = any_mism;
            ST_FIX: restore = 1'b0;
            default: restore = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_flag <= 1'b0;
        else        err_flag <= restore;
    end

    // R3: the flag lasts one cycle
    a_r3_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !err_flag);

    // R6: recovery always returns to RUN
    a_r6_fix_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |=> (state == ST_RUN));

    // R7: no mismatch in RUN gives no flag
    a_r7_match_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && !any_mism) |=> !err_flag);

    // R3: a mismatch in RUN gives the flag
    a_r3_mism_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && any_mism) |=> err_flag);

endmodule

// File: rtl/razor_capture_bank.sv
module razor_capture_bank #(
    parameter int M = 8,
    localparam int W = 2 * M + 1
) (
    input  logic         clk,
    input  logic         clk_dly,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out,
    output logic         err_out
);

    logic [W-1:0] mism_vec;
    logic [W-1:0] shadow_vec;
    logic         restore;

    for (genvar i = 0; i < W; i++) begin : g_bit
        razor_bit_cell u_cell (
            .clk     (clk),
            .clk_dly (clk_dly),
            .rst_n   (rst_n),
            .d       (d_in[i]),
            .restore (restore),
            .q       (q_out[i]),
            .shadow  (shadow_vec[i]),
            .mism    (mism_vec[i])
        );
    end

    razor_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mism_vec (mism_vec),
        .restore  (restore),
        .err_flag (err_out)
    );

    // R4: whenever the flag is up, the word is the previous late sample
    a_r4_err_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_out) |-> (q_out == $past(shadow_vec)));

endmodule

// File: tb/tb_razor_capture_bank.sv
module tb_razor_capture_bank;

    localparam int M = 8;
    localparam int W = 2 * M + 1;

    logic         clk = 1'b0;
    logic         clk_dly = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q_out;
    logic         err_out;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    bit           m_pend = 1'b0;
    bit           m_fix = 1'b0;
    logic [W-1:0] m_late = '0;

    razor_capture_bank #(.M(M)) dut (
        .clk     (clk),
        .clk_dly (clk_dly),
        .rst_n   (rst_n),
        .d_in    (d_in),
        .q_out   (q_out),
        .err_out (err_out)
    );

    always #5 clk = ~clk;
    initial begin
        #3;
        forever #5 clk_dly = ~clk_dly;
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIL%s %s actual=%h expected=%h", "", tag, act, exp);
        end
    endtask

    // one cycle: stale word on the bus at the main edge, good word 1 ns later
    task automatic step(input logic [W-1:0] stale, input logic [W-1:0] good,
                        input bit late, input string tag);
        logic [W-1:0] at_edge;
        logic [W-1:0] q_exp;
        bit           e_exp;
        at_edge = late ? stale : good;
        d_in = at_edge;
        @(posedge clk);
        #1;
        d_in = good;
        #5;
        if (m_pend) begin
            q_exp = m_late; e_exp = 1'b1;
            m_pend = 1'b0; m_fix = 1'b1;
        end else begin
            q_exp = at_edge; e_exp = 1'b0;
            m_fix = 1'b0;
            m_pend = late && (stale != good);
            m_late = good;
        end
        chk({tag, " word"}, q_out, q_exp);
        chk({tag, " flag"}, {{(W-1){1'b0}}, err_out}, {{(W-1){1'b0}}, e_exp});
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #12;
        // R1: reset state
        chk("R1 word", q_out, '0);
        chk("R1 flag", {{(W-1){1'b0}}, err_out}, '0);
        rst_n = 1'b1;

        // R2: on-time words
        step('0, 17'h1ABCD, 1'b0, "R2");
        step('0, 17'h0F0F0, 1'b0, "R2");

        // R3, R4: late arrival, then recovery cycle holding the good word
        step(17'h00001, 17'h1FFFE, 1'b1, "R3");
        step(17'h1FFFE, 17'h1FFFE, 1'b0, "R4");
        step('0, 17'h05555, 1'b0, "R3 clear");

        // R5: top bit alone
        step(17'h0AAAA, 17'h1AAAA, 1'b1, "R5");
        step(17'h1AAAA, 17'h1AAAA, 1'b0, "R5 fix");
        step('0, 17'h00F00, 1'b0, "R5 after");

        // R5: low bit alone
        step(17'h00F01, 17'h00F00, 1'b1, "R5 low");
        step(17'h00F00, 17'h00F00, 1'b0, "R5 low fix");

        // R7: late transition with equal words
        step(17'h12345, 17'h12345, 1'b1, "R7");
        step('0, 17'h00777, 1'b0, "R7 next");

        // R6: late change inside the recovery cycle is ignored
        step(17'h11111, 17'h02222, 1'b1, "R6 set");
        step(17'h03333, 17'h04444, 1'b1, "R6 fix");
        step('0, 17'h06666, 1'b0, "R6");

        // R8: late arrival in the first RUN cycle after recovery
        step(17'h00000, 17'h1F00F, 1'b1, "R8 set");
        step(17'h1F00F, 17'h1F00F, 1'b0, "R8 fix");
        step(17'h00F0F, 17'h10101, 1'b1, "R8");
        step(17'h10101, 17'h10101, 1'b0, "R8 again");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] g;
            logic [W-1:0] s;
            bit           lt;
            g  = W'($urandom);
            s  = ($urandom % 3 == 0) ? g : W'($urandom);
            lt = ($urandom % 4 == 0);
            step(s, g, lt, lt ? "R3 rand" : "R2 rand");
        end

        // R1: reset again mid-run
        d_in = 17'h1FFFF;
        #3;
        rst_n = 1'b0;
        #2;
        chk("R1 reassert word", q_out, '0);
        chk("R1 reassert flag", {{(W-1){1'b0}}, err_out}, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule